// File: doc/BRIEF.md
# Deflection Waveform Polynomial Generator

This block produces two per-line sample streams for driving a CRT's deflection stages: a vertical deflection waveform and an east/west (pincushion-family) correction waveform. Each stream follows a sixth-order polynomial of the line number within the field. The vertical curve can express a sawtooth with linearity (second-order) and S-shaping (third-order) terms. The east/west curve can express a parabola with trapezoid, pincushion and separate top and bottom corner terms.

Each waveform is produced without multipliers by a chain of forward-difference accumulators. The chain is seeded when a field begins and advanced once for every line. Software loads the seven seed values of each chain and a per-waveform gain into shadow registers. These become live only when the next field begins. For every accepted line, the block adds an external per-line correction term for high-voltage variation to the polynomial value. It then multiplies the result by the gain and clips it to fixed upper and lower limits. A larger gain therefore zooms the picture vertically and a smaller one compresses it.

Top module: `defl_wavegen`

## Requirements
- R1: While `rstN` is low, `vertOut`, `ewOut` and `sampleValid` are 0. Both gains reset to unity (256), and all seeds and accumulators reset to 0.
- R2: Until the first `fieldStart` pulse after reset, `lineStrobe` has no effect: `sampleValid` stays 0 and both outputs stay 0.
- R3: A line strobe is accepted when it is high, a field has been seen, and `fieldStart` is low. `sampleValid` is high for exactly the one cycle after each accepted strobe and is low at every other time. The outputs change only in the cycle where `sampleValid` is high.
- R4: Each chain has seeds d0..d6. The sample from the n-th accepted strobe of a field (n counted from 0) is P(n) = sum over k of C(n,k)·dk. Each accepted strobe samples P(n) and then advances every stage k<6 by adding stage k+1 to it. Stage 6 holds its value.
- R5: Seed and gain writes go to shadow registers. The live values are copied from the shadows only on `fieldStart`. A write made in the same cycle as `fieldStart` is applied at the following field.
- R6: The signed correction input of each waveform (`vertCorr`, `ewCorr`) is sampled with the accepted strobe and added to P(n) before scaling.
- R7: The sum is multiplied by the unsigned gain, which has 8 fraction bits (256 = 1.0). The product is shifted right arithmetically by 8, which rounds toward minus infinity.
- R8: The scaled value is clipped to the range [-30000, +30000] before it is output.
- R9: The stage additions and the correction addition saturate at the 32-bit signed limits instead of wrapping.
- R10: When `fieldStart` and `lineStrobe` are high in the same cycle, the field start is taken, the strobe is dropped, and no sample is produced.
- R11: Register map: `cfgSel` 0 selects the vertical set and 1 selects the east/west set. `cfgIdx` 0..6 writes seed dk, with k equal to the index. `cfgIdx` 7 writes the gain from `cfgData[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fieldStart | input | 1 | One-cycle pulse at the start of a field |
| lineStrobe | input | 1 | One-cycle pulse per line |
| cfgWrEn | input | 1 | Shadow register write enable |
| cfgSel | input | 1 | Waveform select: 0 vertical, 1 east/west |
| cfgIdx | input | 3 | Register index: 0..6 seeds, 7 gain |
| cfgData | input | 32 | Write data (signed seed or gain in low 16 bits) |
| vertCorr | input | 16 | Signed per-line correction for the vertical waveform |
| ewCorr | input | 16 | Signed per-line correction for the east/west waveform |
| vertOut | output | 16 | Signed vertical sample |
| ewOut | output | 16 | Signed east/west sample |
| sampleValid | output | 1 | High for the cycle after an accepted strobe |

## Verification
Some properties are checked on every cycle. These are: the one-cycle relation between an accepted strobe and `sampleValid`, the silence before the first field, the holding of both outputs between samples, and the clip range. Only the bench's scenarios can show the numeric content. That covers polynomial values against an independent binomial evaluation, the correction and gain arithmetic with its floor rounding, shadow-register timing, field-start priority, and accumulator saturation along a path where wrap-around would give a different in-range result.

// File: rtl/defl_pkg.sv
package defl_pkg;

  // strobes from the control to each datapath
  typedef struct packed {
    logic load;  // copy shadows to live registers, seed the chain
    logic step;  // sample the chain head and advance the chain
  } defl_ctl_t;

endpackage

// File: rtl/defl_ctrl.sv
module defl_ctrl
  import defl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fieldStart,
  input  logic      lineStrobe,
  output defl_ctl_t ctl,
  output logic      seenField,
  output logic      sampleValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenField <= 1'b0;
    else if (fieldStart) seenField <= 1'b1;
  end

  // field start wins over a line strobe in the same cycle
  always_comb begin
    ctl.load = fieldStart;
    ctl.step = lineStrobe && seenField && !fieldStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleValid <= 1'b0;
    else sampleValid <= ctl.step;
  end

endmodule

// File: rtl/defl_path.sv
module defl_path
  import defl_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int OUT_W     = 16,
  parameter int ORD       = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int IDX_W     = 3,
  parameter int LIM_HI    = 30000,
  parameter int LIM_LO    = -30000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  defl_ctl_t               ctl,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [ACC_W-1:0]        wrData,
  input  logic signed [OUT_W-1:0] corr,
  output logic signed [OUT_W-1:0] sample
);

  localparam int PROD_W = ACC_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(1) << GAIN_FRAC;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] HI_EXT = PROD_W'(LIM_HI);
  localparam logic signed [PROD_W-1:0] LO_EXT = PROD_W'(LIM_LO);

  function automatic logic signed [ACC_W-1:0] satAdd(
    input logic signed [ACC_W-1:0] a,
    input logic signed [ACC_W-1:0] b
  );
    logic signed [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return s[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] seedShadow [ORD+1];
  logic signed [ACC_W-1:0] acc        [ORD+1];
  logic signed [ACC_W-1:0] accNext    [ORD+1];
  logic [GAIN_W-1:0]       gainShadow;
  logic [GAIN_W-1:0]       gainLive;

  // shadow register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k <= ORD; k++) seedShadow[k] <= '0;
      gainShadow <= GAIN_RST;
    end else if (wrEn) begin
      for (int k = 0; k <= ORD; k++)
        if (wrIdx == IDX_W'(k)) seedShadow[k] <= wrData;
      if (wrIdx == IDX_W'(ORD + 1)) gainShadow <= wrData[GAIN_W-1:0];
    end
  end

  // forward-difference chain: each stage adds its upper neighbour
  for (genvar k = 0; k <= ORD; k++) begin : gStage
    if (k < ORD) begin : gAdv
      assign accNext[k] = satAdd(acc[k], acc[k+1]);
    end else begin : gTop
      assign accNext[k] = acc[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k <= ORD; k++) acc[k] <= '0;
      gainLive <= GAIN_RST;
    end else if (ctl.load) begin
      for (int k = 0; k <= ORD; k++) acc[k] <= seedShadow[k];
      gainLive <= gainShadow;
    end else if (ctl.step) begin
      for (int k = 0; k <= ORD; k++) acc[k] <= accNext[k];
    end
  end

  // correction, gain and clip
  logic signed [ACC_W-1:0]  withCorr;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [OUT_W-1:0]  clipped;

  assign withCorr = satAdd(acc[0], ACC_W'(corr));
  assign prod     = PROD_W'(withCorr) * $signed({{(PROD_W-GAIN_W){1'b0}}, gainLive});
  assign scaled   = prod >>> GAIN_FRAC;

  always_comb begin
    if (scaled > HI_EXT)      clipped = OUT_W'(LIM_HI);
    else if (scaled < LO_EXT) clipped = OUT_W'(LIM_LO);
    else                      clipped = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sample <= '0;
    else if (ctl.step) sample <= clipped;
  end

endmodule

// File: rtl/defl_wavegen.sv
module defl_wavegen
  import defl_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int OUT_W     = 16,
  parameter int ORD       = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int LIM_HI    = 30000,
  parameter int LIM_LO    = -30000,
  localparam int IDX_W    = $clog2(ORD + 2)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fieldStart,
  input  logic                    lineStrobe,
  input  logic                    cfgWrEn,
  input  logic                    cfgSel,
  input  logic [IDX_W-1:0]        cfgIdx,
  input  logic [ACC_W-1:0]        cfgData,
  input  logic signed [OUT_W-1:0] vertCorr,
  input  logic signed [OUT_W-1:0] ewCorr,
  output logic signed [OUT_W-1:0] vertOut,
  output logic signed [OUT_W-1:0] ewOut,
  output logic                    sampleValid
);

  localparam int N_WAVE = 2;

  defl_ctl_t ctl;
  logic      seenField;

  defl_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fieldStart (fieldStart),
    .lineStrobe (lineStrobe),
    .ctl        (ctl),
    .seenField  (seenField),
    .sampleValid(sampleValid)
  );

  logic signed [OUT_W-1:0] corrIn  [N_WAVE];
  logic signed [OUT_W-1:0] pathOut [N_WAVE];

  assign corrIn[0] = vertCorr;
  assign corrIn[1] = ewCorr;

  for (genvar w = 0; w < N_WAVE; w++) begin : gWave
    defl_path #(
      .ACC_W    (ACC_W),
      .OUT_W    (OUT_W),
      .ORD      (ORD),
      .GAIN_W   (GAIN_W),
      .GAIN_FRAC(GAIN_FRAC),
      .IDX_W    (IDX_W),
      .LIM_HI   (LIM_HI),
      .LIM_LO   (LIM_LO)
    ) uPath (
      .clk   (clk),
      .rstN  (rstN),
      .ctl   (ctl),
      .wrEn  (cfgWrEn && (cfgSel == 1'(w))),
      .wrIdx (cfgIdx),
      .wrData(cfgData),
      .corr  (corrIn[w]),
      .sample(pathOut[w])
    );
  end

  assign vertOut = pathOut[0];
  assign ewOut   = pathOut[1];

endmodule

// File: rtl/defl_chk.sv
module defl_chk #(
  parameter int OUT_W  = 16,
  parameter int LIM_HI = 30000,
  parameter int LIM_LO = -30000
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    fieldStart,
  input logic                    lineStrobe,
  input logic                    seenField,
  input logic                    sampleValid,
  input logic signed [OUT_W-1:0] vertOut,
  input logic signed [OUT_W-1:0] ewOut
);

  localparam logic signed [OUT_W-1:0] HI = OUT_W'(LIM_HI);
  localparam logic signed [OUT_W-1:0] LO = OUT_W'(LIM_LO);

  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> ($past(lineStrobe) && !$past(fieldStart)));

  // R3
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && seenField && !fieldStart) |=> sampleValid);

  // R10
  field_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> !sampleValid);

  // R2
  quiet_before_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenField |-> (!sampleValid && vertOut == '0 && ewOut == '0));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(vertOut) && $stable(ewOut)));

  // R8
  clip_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vertOut <= HI && vertOut >= LO && ewOut <= HI && ewOut >= LO));

endmodule

bind defl_wavegen defl_chk #(
  .OUT_W (OUT_W),
  .LIM_HI(LIM_HI),
  .LIM_LO(LIM_LO)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .fieldStart (fieldStart),
  .lineStrobe (lineStrobe),
  .seenField  (seenField),
  .sampleValid(sampleValid),
  .vertOut    (vertOut),
  .ewOut      (ewOut)
);

// File: tb/sim_defl_wavegen.sv
`timescale 1ns/1ps
module sim_defl_wavegen;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              fieldStart = 1'b0;
  logic              lineStrobe = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic              cfgSel = 1'b0;
  logic [2:0]        cfgIdx = '0;
  logic [31:0]       cfgData = '0;
  logic signed [15:0] vertCorr = '0;
  logic signed [15:0] ewCorr = '0;
  logic signed [15:0] vertOut;
  logic signed [15:0] ewOut;
  logic              sampleValid;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  defl_wavegen u0 (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .lineStrobe(lineStrobe),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .vertCorr(vertCorr), .ewCorr(ewCorr), .vertOut(vertOut), .ewOut(ewOut),
    .sampleValid(sampleValid)
  );

  // per-line corrections {vertical, east/west}
  localparam int N_LINES = 12;
  localparam int CORR_TAB [N_LINES][2] = '{
    '{0, 0}, '{5, -3}, '{-7, 1}, '{0, 2}, '{100, -100}, '{-1, -1},
    '{3, 0}, '{0, 9}, '{-250, 40}, '{11, -5}, '{0, 0}, '{-2, 7}
  };

  longint vSeed [7] = '{-1000, 20, 3, 1, 0, 0, 1};
  longint eSeed [7] = '{500, -40, 8, 0, 2, -1, 0};

  task automatic check(string req, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint binom(int n, int k);
    longint r = 1;
    if (k > n) return 0;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  function automatic longint polyAt(longint d [7], int n);
    longint s = 0;
    for (int k = 0; k < 7; k++) s += binom(n, k) * d[k];
    return s;
  endfunction

  function automatic longint expOut(longint p, longint c, longint g);
    longint q;
    q = ((p + c) * g) >>> 8;
    if (q > 30000) q = 30000;
    if (q < -30000) q = -30000;
    return q;
  endfunction

  task automatic wr(logic sel, int idx, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgIdx = 3'(idx); cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic newField();
    @(negedge clk);
    fieldStart = 1'b1;
    @(negedge clk);
    fieldStart = 1'b0;
  endtask

  // strobe one line; on return the registered sample is visible
  task automatic line(int vc, int ec);
    @(negedge clk);
    lineStrobe = 1'b1; vertCorr = 16'(vc); ewCorr = 16'(ec);
    @(negedge clk);
    lineStrobe = 1'b0; vertCorr = '0; ewCorr = '0;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 vertOut", vertOut, 0);
    check("R1 ewOut", ewOut, 0);
    check("R1 valid", sampleValid, 0);
    rstN = 1'b1;

    // R2: strobes before any field start
    line(50, 50);
    check("R2 valid", sampleValid, 0);
    check("R2 vertOut", vertOut, 0);
    check("R2 ewOut", ewOut, 0);

    // R11: load both seed sets and the east/west gain (1.5)
    for (int k = 0; k < 7; k++) begin
      wr(1'b0, k, 32'(vSeed[k]));
      wr(1'b1, k, 32'(eSeed[k]));
    end
    wr(1'b1, 7, 32'd384);
    newField();

    // R4, R6, R7: table walk
    for (int i = 0; i < N_LINES; i++) begin
      line(CORR_TAB[i][0], CORR_TAB[i][1]);
      check("R3 valid", sampleValid, 1);
      check("R4/R6 vertOut", vertOut, expOut(polyAt(vSeed, i), CORR_TAB[i][0], 256));
      check("R7 ewOut", ewOut, expOut(polyAt(eSeed, i), CORR_TAB[i][1], 384));
    end
    @(negedge clk);
    check("R3 valid drop", sampleValid, 0);

    // R5: mid-field write waits for next field
    newField();
    line(0, 0);
    check("R5 first", vertOut, -1000);
    wr(1'b0, 0, 32'd777);
    line(0, 0);
    check("R5 old seeds", vertOut, -980);
    newField();
    line(0, 0);
    check("R5 new seeds", vertOut, 777);

    // R10: field start and strobe together
    @(negedge clk);
    fieldStart = 1'b1; lineStrobe = 1'b1;
    @(negedge clk);
    fieldStart = 1'b0; lineStrobe = 1'b0;
    check("R10 no sample", sampleValid, 0);
    line(0, 0);
    check("R10 restart", vertOut, 777);

    // R8: clipping both ways
    wr(1'b0, 0, 32'd40000);
    wr(1'b1, 0, -32'sd40000);
    for (int k = 1; k < 7; k++) begin
      wr(1'b0, k, 32'd0);
      wr(1'b1, k, 32'd0);
    end
    wr(1'b1, 7, 32'd256);
    newField();
    line(0, 0);
    check("R8 high", vertOut, 30000);
    check("R8 low", ewOut, -30000);

    // R7: floor rounding of negative products
    wr(1'b0, 0, -32'sd3);
    wr(1'b0, 7, 32'd128);
    newField();
    line(0, 0);
    check("R7 floor", vertOut, -2);

    // R9: saturation then recovery into range
    wr(1'b0, 7, 32'd256);
    wr(1'b0, 0, 32'd2147483600);
    wr(1'b0, 1, 32'd1000);
    wr(1'b0, 2, 32'h80000000);
    newField();
    line(0, 0);
    check("R9 line0", vertOut, 30000);
    line(0, 0);
    check("R9 line1", vertOut, 30000);
    line(0, 0);
    check("R9 saturated", vertOut, 999);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule